// File: doc/BRIEF.md
# Shared Gray-Count Wilkinson Conversion Array

This block is the digital back end of a parallel ramp-compare (Wilkinson) digitizer built over an array of analog sampling cells. A start pulse opens a conversion window. During the window a single binary counter steps from zero to its all-ones ceiling. Its value is sent to every cell on one shared bus in Gray code, so no clock has to be routed into the cells. Each cell has a stop line that its comparator drives. On the first assertion of that line within a window, the cell freezes the Gray code present on the bus. All cells therefore digitize at once, and each cell's cost is one capture register and two flag bits.

The cells are grouped into blocks of equal size. When the window closes, every cell that never saw a stop is given the ceiling value and marked as overflowed. Next the sequencer reads the cells out one per clock in ascending index order. Each stored code is converted back to binary on the way out, and a done flag is set once the last cell has been sent. The analog ramp and the comparators are outside the block. In a system the comparator outputs connect to `stop_in`, and the readout port feeds an event buffer.

Top module: `wk_conv_array`

## Requirements
- R1: After reset, `busy`, `rd_valid` and `done` are 0.
- R2: Take the clock edge that samples `start` as edge 0. If a cell's stop line is high first at edge k+1 (k = 0 … 2^CNT_W−1), that cell reads out the binary value k with `rd_ovf` = 0. This covers k = 0 and k = 2^CNT_W−1.
- R3: Within a window only the first stop event of a cell is captured. Stop pulses after it leave that cell's result unchanged.
- R4: A cell that sees no stop event during the window reads out 2^CNT_W−1 with `rd_ovf` = 1.
- R5: Every cell converts in parallel: cells whose stop lines rise on the same edge read out the same value.
- R6: The window lasts exactly 2^CNT_W clocks. The first `rd_valid` appears after edge 2^CNT_W+1, and `busy` is high from edge 0 until then.
- R7: Readout sends N_BLOCKS×BLK_CELLS values on consecutive clocks, with `rd_idx` going 0, 1, 2, … up to the last cell.
- R8: `done` goes high one clock after the last valid word. At that point `busy` and `rd_valid` are 0. It stays high until the next accepted `start`, which clears it.
- R9: A `start` that arrives while `busy` is high is ignored, and the ongoing conversion or readout continues undisturbed.
- R10: Between consecutive clocks the shared `gray_bus` changes in at most one bit. During the window it carries the Gray code of the count, where the Gray code of b is b XOR (b>>1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Opens a conversion window when idle |
| stop_in | input | N_BLOCKS*BLK_CELLS | Comparator stop line per cell (bit i = cell i) |
| busy | output | 1 | Conversion or readout in progress |
| gray_bus | output | CNT_W | Shared Gray-coded count seen by the cells |
| rd_valid | output | 1 | Readout word valid |
| rd_idx | output | clog2(cells) | Cell index of the readout word |
| rd_data | output | CNT_W | Binary conversion result |
| rd_ovf | output | 1 | Cell saw no stop during the window |
| done | output | 1 | Readout of the whole array finished |

## Verification
The hardest situation to reach is a cell whose stop line rises exactly on the last count of the window. That edge is also the one on which every silent cell is forced to overflow, so a capture there must still count as a hit. The stimulus puts stop events on exact cycle offsets counted from the start edge. One directed run places events at count 0, at the ceiling and on many evenly spaced counts. Other runs put all cells on one shared count, leave all cells silent, or use seeded random counts with extra late pulses. Start pulses are also injected in the middle of the window and in the middle of readout.

// File: rtl/wk_pkg.sv
package wk_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CONV = 2'd1,
    ST_READ = 2'd2
  } wk_state_e;

  // Binary to reflected Gray code.
  function automatic logic [31:0] to_gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  // Reflected Gray code back to binary (prefix XOR from the top bit).
  function automatic logic [31:0] from_gray(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

endpackage

// File: rtl/wk_gray_counter.sv
module wk_gray_counter #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             en,
  output logic [CNT_W-1:0] gray_q,
  output logic             at_max
);
  import wk_pkg::*;

  logic [CNT_W-1:0] bin_q;
  logic [CNT_W-1:0] bin_nx;

  assign at_max = (bin_q == {CNT_W{1'b1}});
  assign bin_nx = bin_q + 1'b1;

  // Binary and Gray registers advance together so the bus is glitch-free.
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      bin_q  <= '0;
      gray_q <= '0;
    end else if (en && !at_max) begin
      bin_q  <= bin_nx;
      gray_q <= CNT_W'(to_gray(32'(bin_nx)));
    end
  end

endmodule

// File: rtl/wk_cell_block.sv
module wk_cell_block #(
  parameter int CNT_W     = 11,
  parameter int BLK_CELLS = 64,
  localparam int CSEL_W   = $clog2(BLK_CELLS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr,
  input  logic                 arm,
  input  logic                 last,
  input  logic [CNT_W-1:0]     gray_in,
  input  logic [BLK_CELLS-1:0] stop,
  input  logic [CSEL_W-1:0]    rd_sel,
  output logic [CNT_W-1:0]     rd_gray,
  output logic                 rd_ovf
);

  logic [CNT_W-1:0]     code_all [BLK_CELLS];
  logic [BLK_CELLS-1:0] ovf_all;

  for (genvar c = 0; c < BLK_CELLS; c++) begin : g_cell
    logic [CNT_W-1:0] code_q;
    logic             hit_q;
    logic             ovf_q;

    // First stop in the window freezes the shared code; a silent cell is
    // forced to the final code and flagged on the last count.
    always_ff @(posedge clk) begin
      if (rst) begin
        code_q <= '0;
        hit_q  <= 1'b0;
        ovf_q  <= 1'b0;
      end else if (clr) begin
        hit_q  <= 1'b0;
        ovf_q  <= 1'b0;
      end else if (arm && !hit_q) begin
        if (stop[c]) begin
          code_q <= gray_in;
          hit_q  <= 1'b1;
        end else if (last) begin
          code_q <= gray_in;
          hit_q  <= 1'b1;
          ovf_q  <= 1'b1;
        end
      end
    end

    assign code_all[c] = code_q;
    assign ovf_all[c]  = ovf_q;
  end

  assign rd_gray = code_all[rd_sel];
  assign rd_ovf  = ovf_all[rd_sel];

endmodule

// File: rtl/wk_conv_array.sv
module wk_conv_array #(
  parameter int CNT_W     = 11,
  parameter int N_BLOCKS  = 8,
  parameter int BLK_CELLS = 64,
  localparam int N_CELLS  = N_BLOCKS * BLK_CELLS,
  localparam int IDX_W    = $clog2(N_CELLS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [N_CELLS-1:0] stop_in,
  output logic               busy,
  output logic [CNT_W-1:0]   gray_bus,
  output logic               rd_valid,
  output logic [IDX_W-1:0]   rd_idx,
  output logic [CNT_W-1:0]   rd_data,
  output logic               rd_ovf,
  output logic               done
);
  import wk_pkg::*;

  localparam int CSEL_W = $clog2(BLK_CELLS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_CELLS - 1);

  wk_state_e        state_q;
  logic [IDX_W-1:0] rd_ptr_q;
  logic             rd_valid_q;
  logic [IDX_W-1:0] rd_idx_q;
  logic [CNT_W-1:0] rd_data_q;
  logic             rd_ovf_q;
  logic             done_q;

  logic             busy_int;
  logic             start_acc;
  logic             conv_en;
  logic             at_max;
  logic [CNT_W-1:0] gray_q;

  logic [CNT_W-1:0] blk_gray [N_BLOCKS];
  logic             blk_ovf  [N_BLOCKS];
  logic [CSEL_W-1:0] cell_sel;
  logic [IDX_W-1:0]  blk_sel;

  assign busy_int  = (state_q != ST_IDLE) || rd_valid_q;
  assign start_acc = start && !busy_int;
  assign conv_en   = (state_q == ST_CONV);
  assign cell_sel  = rd_ptr_q[CSEL_W-1:0];
  assign blk_sel   = rd_ptr_q >> CSEL_W;

  wk_gray_counter #(.CNT_W(CNT_W)) i_cnt (
    .clk    (clk),
    .rst    (rst),
    .clr    (start_acc),
    .en     (conv_en),
    .gray_q (gray_q),
    .at_max (at_max)
  );

  for (genvar b = 0; b < N_BLOCKS; b++) begin : g_blk
    wk_cell_block #(.CNT_W(CNT_W), .BLK_CELLS(BLK_CELLS)) i_blk (
      .clk     (clk),
      .rst     (rst),
      .clr     (start_acc),
      .arm     (conv_en),
      .last    (at_max),
      .gray_in (gray_q),
      .stop    (stop_in[b*BLK_CELLS +: BLK_CELLS]),
      .rd_sel  (cell_sel),
      .rd_gray (blk_gray[b]),
      .rd_ovf  (blk_ovf[b])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      rd_ptr_q   <= '0;
      rd_valid_q <= 1'b0;
      rd_idx_q   <= '0;
      rd_data_q  <= '0;
      rd_ovf_q   <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      rd_valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_acc) begin
            state_q <= ST_CONV;
            done_q  <= 1'b0;
          end
        end
        ST_CONV: begin
          if (at_max) begin
            state_q  <= ST_READ;
            rd_ptr_q <= '0;
          end
        end
        ST_READ: begin
          rd_valid_q <= 1'b1;
          rd_idx_q   <= rd_ptr_q;
          rd_data_q  <= CNT_W'(from_gray(32'(blk_gray[blk_sel])));
          rd_ovf_q   <= blk_ovf[blk_sel];
          if (rd_ptr_q == LAST_IDX) begin
            state_q <= ST_IDLE;
          end else begin
            rd_ptr_q <= rd_ptr_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
      if (rd_valid_q && (rd_idx_q == LAST_IDX)) begin
        done_q <= 1'b1;
      end
    end
  end

  assign busy     = busy_int;
  assign gray_bus = gray_q;
  assign rd_valid = rd_valid_q;
  assign rd_idx   = rd_idx_q;
  assign rd_data  = rd_data_q;
  assign rd_ovf   = rd_ovf_q;
  assign done     = done_q;

endmodule

// File: rtl/wk_conv_checker.sv
module wk_conv_checker #(
  parameter int CNT_W = 11,
  parameter int IDX_W = 9
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             busy,
  input logic [CNT_W-1:0] gray_bus,
  input logic             rd_valid,
  input logic [IDX_W-1:0] rd_idx,
  input logic [CNT_W-1:0] rd_data,
  input logic             rd_ovf,
  input logic             done
);

  // R10
  gray_step_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(gray_bus ^ $past(gray_bus)) <= 1);

  // R7
  rd_order_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && $past(rd_valid)) |-> (rd_idx == IDX_W'($past(rd_idx) + 1'b1)));

  // R4
  ovf_ceiling_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && rd_ovf) |-> (rd_data == {CNT_W{1'b1}}));

  // R8
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done);

  // R8
  done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!rd_valid && !busy));

  // R9
  start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && start) |=> (rd_valid || done));

endmodule

bind wk_conv_array wk_conv_checker #(.CNT_W(CNT_W), .IDX_W(IDX_W)) i_wk_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .busy     (busy),
  .gray_bus (gray_bus),
  .rd_valid (rd_valid),
  .rd_idx   (rd_idx),
  .rd_data  (rd_data),
  .rd_ovf   (rd_ovf),
  .done     (done)
);

// File: tb/test_wk_conv_array.sv
module test_wk_conv_array;
  localparam int CNT_W   = 11;
  localparam int NB      = 8;
  localparam int BC      = 64;
  localparam int NC      = NB * BC;
  localparam int IDX_W   = $clog2(NC);
  localparam int MAXC    = (1 << CNT_W) - 1;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start = 1'b0;
  logic [NC-1:0]    stop_in = '0;
  logic             busy;
  logic [CNT_W-1:0] gray_bus;
  logic             rd_valid;
  logic [IDX_W-1:0] rd_idx;
  logic [CNT_W-1:0] rd_data;
  logic             rd_ovf;
  logic             done;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  int tgt  [NC];
  int tgt2 [NC];

  // 250 MHz: 4 time units per period.
  always #2 clk = ~clk;

  wk_conv_array #(.CNT_W(CNT_W), .N_BLOCKS(NB), .BLK_CELLS(BC)) i_wk_conv_array (
    .clk(clk), .rst(rst), .start(start), .stop_in(stop_in), .busy(busy),
    .gray_bus(gray_bus), .rd_valid(rd_valid), .rd_idx(rd_idx),
    .rd_data(rd_data), .rd_ovf(rd_ovf), .done(done)
  );

  function automatic int gray_of(input int b);
    return b ^ (b >> 1);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One full window plus readout; mode picks the stop pattern.
  task automatic run_window(input int mode);
    int gray_bad = 0;
    for (int c = 0; c < NC; c++) begin
      tgt2[c] = -1;
      case (mode)
        0: tgt[c] = (c == NC-1) ? MAXC : (c == NC-2) ? -1 : c * 4;
        1: begin
          tgt[c] = ($urandom % 8 == 0) ? -1 : int'($urandom % (MAXC + 1));
          if (tgt[c] >= 0 && ($urandom % 3 == 0))
            tgt2[c] = tgt[c] + 1 + int'($urandom % 300);
        end
        2: tgt[c] = 777;
        default: tgt[c] = -1;
      endcase
    end
    @(negedge clk); start = 1'b1; stop_in = '0;
    @(negedge clk); start = 1'b0;
    check(done == 1'b0, "R8 done cleared by start", int'(done), 0);
    check(busy == 1'b1, "R6 busy in window", int'(busy), 1);
    for (int k = 0; k <= MAXC; k++) begin
      if (int'(gray_bus) != gray_of(k)) gray_bad++;
      for (int c = 0; c < NC; c++) stop_in[c] = (tgt[c] == k) || (tgt2[c] == k);
      start = (k == 50);   // R9: ignored mid-window
      @(negedge clk);
    end
    stop_in = '0; start = 1'b0;
    check(gray_bad == 0, "R10 gray bus sequence", gray_bad, 0);
    check(rd_valid == 1'b0 && busy == 1'b1, "R6 no data before window end",
          int'(rd_valid), 0);
    @(negedge clk);
    for (int j = 0; j < NC; j++) begin
      int ev;
      int eo;
      string tag;
      ev  = (tgt[j] < 0) ? MAXC : tgt[j];
      eo  = (tgt[j] < 0) ? 1 : 0;
      tag = (eo == 1) ? "R4 overflow" : (tgt2[j] >= 0) ? "R3 first event" :
            (mode == 2) ? "R5 parallel" : "R2 value";
      if (j == 0) check(rd_valid == 1'b1, "R6 first word timing", int'(rd_valid), 1);
      check(rd_valid == 1'b1 && int'(rd_idx) == j, "R7 index order", int'(rd_idx), j);
      check(int'(rd_data) == ev && int'(rd_ovf) == eo, tag,
            int'(rd_data) * 2 + int'(rd_ovf), ev * 2 + eo);
      start = (j == 10);   // R9: ignored mid-readout
      @(negedge clk);
    end
    start = 1'b0;
    check(done == 1'b1 && rd_valid == 1'b0 && busy == 1'b0, "R8 done after last",
          int'(done), 1);
    @(negedge clk);
    check(done == 1'b1, "R8 done holds", int'(done), 1);
  endtask

  initial begin
    void'($urandom(32'd1357));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(busy == 1'b0 && rd_valid == 1'b0 && done == 1'b0, "R1 reset state",
          int'(busy) + int'(rd_valid) + int'(done), 0);
    run_window(0);
    run_window(1);
    run_window(2);
    run_window(3);
    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule